// File: doc/BRIEF.md
# Decimal Text to Binary Accumulator

This block turns a stream of ASCII decimal characters into the unsigned binary number they spell. Characters arrive one per cycle with a valid strobe, most significant digit first, and each accepted digit updates an internal accumulator to ten times its old value plus the new digit. There is no limit on the number of digits. The only limit is the accumulator width `W`. The multiply by ten is formed by shifting and adding: four times the value, plus the value, then doubled. There are no per-position tables and no multiplier.

A `start` pulse opens a new number and clears the accumulator and both flags. A character flagged as the last one closes the number: `done` pulses once and the result holds. A character outside the digit range raises a sticky `bad_char` flag, and the block then ignores input until the next `start`. A step whose true result does not fit in `W` bits raises a sticky `ovf` flag.

The controller has four named states:
- `S_IDLE`: after reset, waiting for the first `start`.
- `S_RUN`: accepting characters.
- `S_HALT`: entered on a non-digit; input is ignored.
- `S_FIN`: entered on the last character; the result is held.

The transitions are:
- `start` moves any state to `S_RUN`.
- A non-digit accepted in `S_RUN` moves to `S_HALT`.
- A digit flagged last, accepted in `S_RUN`, moves to `S_FIN`.
- All other cases stay put.

Top module: `dec_text_to_bin`

## Requirements
- R1: After reset, `value` is 0 and `done`, `bad_char` and `ovf` are 0. Characters presented before the first `start` change nothing.
- R2: A `start` pulse clears `value`, `bad_char` and `ovf` at that clock edge. A character presented in the same cycle as `start` is ignored.
- R3: Bytes 0x30 to 0x39 are digits 0 to 9. At the edge that accepts a digit, `value` becomes (old `value` × 10 + digit) modulo 2^W, with digits taken most significant first.
- R4: An accepted byte outside 0x30 to 0x39 sets `bad_char` and leaves `value` unchanged. `bad_char` stays set until `start`.
- R5: When the true result (old value × 10 + digit) of an accepted digit exceeds 2^W − 1, `ovf` is set at that edge. `ovf` stays set until `start`.
- R6: `done` is 1 for exactly the one cycle after the edge that accepts a character with `chr_last` = 1, whether that character is a digit or not. It is 0 at all other times.
- R7: After a non-digit, or after the last character, further characters leave `value`, the flags and `done` unchanged until the next `start`.
- R8: In a cycle with `chr_vld` = 0, `value` and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new number; clears accumulator and flags |
| chr_vld | input | 1 | A character is presented this cycle |
| chr_byte | input | 8 | ASCII code of the character |
| chr_last | input | 1 | The presented character ends the number |
| value | output | W | Accumulated binary value |
| done | output | 1 | One-cycle pulse after the last character is taken |
| bad_char | output | 1 | Sticky: a non-digit was received |
| ovf | output | 1 | Sticky: the value exceeded W bits |

## Verification
Two functions can fall in the same cycle:
- The last digit can also be the one that overflows. The bench provokes this with the digit string one above 2^32 − 1 and with longer random strings, and it requires `done` and `ovf` together in the cycle after that edge.
- A non-digit can carry the last marker. The bench requires `done` together with `bad_char`, with `value` unchanged.

A `start` presented with a character in the same cycle is judged by requiring a zero `value` afterwards. Random strings, some with stray characters, are checked character by character against a 64-bit model in the bench.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2,
        S_FIN  = 2'd3
    } dtb_state_t;

    localparam logic [7:0] DIGIT_BASE = 8'h30;
    localparam int         DIGIT_W    = 4;
endpackage

// File: rtl/dtb_digit_check.sv
module dtb_digit_check
    import dtb_pkg::*;
(
    input  logic [7:0]         code,
    output logic [DIGIT_W-1:0] digit,
    output logic               is_digit
);
    logic [7:0] diff;

    always_comb begin
        diff     = code - DIGIT_BASE;
        is_digit = (diff < 8'd10);
        digit    = diff[DIGIT_W-1:0];
    end

    // R3 / R4: range decision agrees with a direct bound comparison
    always_comb begin
        a_r4_digit_range: assert (is_digit == ((code >= 8'h30) && (code <= 8'h39)));
    end
endmodule

// File: rtl/dtb_mul10_add.sv
module dtb_mul10_add
    import dtb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]       acc,
    input  logic [DIGIT_W-1:0] digit,
    output logic [W-1:0]       res,
    output logic               step_ovf
);
    localparam int WX = W + 4;

    logic [WX-1:0] wide, quad, five, ten, sum;

    always_comb begin
        wide     = {4'b0000, acc};
        quad     = wide << 2;
        five     = quad + wide;
        ten      = five << 1;
        sum      = ten + {{(WX-DIGIT_W){1'b0}}, digit};
        res      = sum[W-1:0];
        step_ovf = |sum[WX-1:W];
    end
endmodule

// File: rtl/dec_text_to_bin.sv
module dec_text_to_bin
    import dtb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         chr_vld,
    input  logic [7:0]   chr_byte,
    input  logic         chr_last,
    output logic [W-1:0] value,
    output logic         done,
    output logic         bad_char,
    output logic         ovf
);
    dtb_state_t          st, st_nx;
    logic [DIGIT_W-1:0]  dig;
    logic                is_dig;
    logic [W-1:0]        nxt_val;
    logic                step_ovf;
    logic                take;

    dtb_digit_check u_chk (
        .code     (chr_byte),
        .digit    (dig),
        .is_digit (is_dig)
    );

    dtb_mul10_add #(.W(W)) u_mac (
        .acc      (value),
        .digit    (dig),
        .res      (nxt_val),
        .step_ovf (step_ovf)
    );

    assign take = chr_vld && !start && (st == S_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start) st_nx = S_RUN;
            S_RUN: begin
                if (start)                      st_nx = S_RUN;
                else if (take && !is_dig)       st_nx = S_HALT;
                else if (take && chr_last)      st_nx = S_FIN;
            end
            S_HALT: if (start) st_nx = S_RUN;
            S_FIN:  if (start) st_nx = S_RUN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value    <= '0;
            done     <= 1'b0;
            bad_char <= 1'b0;
            ovf      <= 1'b0;
        end else if (start) begin
            value    <= '0;
            done     <= 1'b0;
            bad_char <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            done <= take && chr_last;
            if (take) begin
                if (is_dig) begin
                    value <= nxt_val;
                    if (step_ovf) ovf <= 1'b1;
                end else begin
                    bad_char <= 1'b1;
                end
            end
        end
    end

    // R2: start clears accumulator and flags
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (value == '0 && !bad_char && !ovf && !done));
    // R4: error flag sticky
    a_r4_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_char && !start) |=> bad_char);
    // R5: overflow flag sticky
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !start) |=> ovf);
    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: halted or finished keeps value
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_HALT || st == S_FIN) && !start) |=> $stable(value));
    // R8: no valid character, no change
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!chr_vld && !start) |=> ($stable(value) && $stable(bad_char) && $stable(ovf)));
endmodule

// File: tb/sim_dec_text_to_bin.sv
module sim_dec_text_to_bin;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         chr_vld = 1'b0;
    logic [7:0]   chr_byte = 8'h00;
    logic         chr_last = 1'b0;
    logic [W-1:0] value;
    logic         done, bad_char, ovf;

    int total = 0;
    int bad = 0;

    // model
    logic [63:0] m_val;
    logic        m_err, m_ovf, m_done;
    int          m_mode; // 0 idle, 1 run, 2 ignoring

    always #10 clk = ~clk;

    dec_text_to_bin #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .chr_vld(chr_vld),
        .chr_byte(chr_byte), .chr_last(chr_last), .value(value),
        .done(done), .bad_char(bad_char), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic is_dig(input logic [7:0] c);
        return (c >= 8'h30) && (c <= 8'h39);
    endfunction

    task automatic check_all(input string tv);
        chk({tv, " value"}, {32'd0, value}, m_val);
        chk("R4 bad_char", {63'd0, bad_char}, {63'd0, m_err});
        chk("R5 ovf", {63'd0, ovf}, {63'd0, m_ovf});
        chk("R6 done", {63'd0, done}, {63'd0, m_done});
    endtask

    task automatic do_start(input logic with_chr);
        @(negedge clk);
        start = 1'b1;
        chr_vld = with_chr;
        chr_byte = 8'h37;
        chr_last = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chr_vld = 1'b0;
        m_val = 0; m_err = 0; m_ovf = 0; m_done = 0; m_mode = 1;
        check_all("R2");
    endtask

    task automatic put(input logic [7:0] c, input logic l);
        logic [63:0] t;
        string tv;
        @(negedge clk);
        chk("R6 done low between chars", {63'd0, done}, 64'd0);
        chr_vld = 1'b1; chr_byte = c; chr_last = l;
        m_done = 0;
        tv = (m_mode == 0) ? "R1" : (m_mode == 2) ? "R7" : is_dig(c) ? "R3" : "R4";
        if (m_mode == 1) begin
            if (is_dig(c)) begin
                t = m_val * 10 + {60'd0, c[3:0]};
                if (t > 64'hFFFF_FFFF) m_ovf = 1;
                m_val = {32'd0, t[31:0]};
            end else begin
                m_err = 1;
            end
            if (l) m_done = 1;
            if (l || !is_dig(c)) m_mode = 2;
        end
        @(negedge clk);
        chr_vld = 1'b0; chr_last = 1'b0;
        check_all(tv);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++)
            put(s[i], i == s.len() - 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4321);
        m_val = 0; m_err = 0; m_ovf = 0; m_done = 0; m_mode = 0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        // R1: chars before first start
        put(8'h35, 1'b0);
        put(8'h39, 1'b1);

        // R3 basic
        do_start(1'b0); send_str("456");
        do_start(1'b0); send_str("0");
        do_start(1'b0); send_str("4294967295");
        // R5 overflow on last digit together with done
        do_start(1'b0); send_str("4294967296");
        do_start(1'b0); send_str("42949672950");
        do_start(1'b0); send_str("9999999999999999999999999");
        // R7: chars after done ignored
        put(8'h31, 1'b0); put(8'h32, 1'b1);
        // R4 bad char then more ignored
        do_start(1'b0); send_str("12a34");
        do_start(1'b0); send_str("/"); // bad char as last: done with error
        do_start(1'b0); send_str(":");
        // R2 start with a character in the same cycle
        do_start(1'b1); send_str("8");
        // R8 gap cycles then continue
        do_start(1'b0); put(8'h31, 1'b0);
        repeat (4) @(negedge clk);
        check_all("R8");
        put(8'h32, 1'b1);
        // R2 clears flags after overflow and error
        do_start(1'b0); send_str("99999999999x");

        // random
        for (int n = 0; n < 300; n++) begin
            int len;
            do_start(1'b0);
            len = 1 + int'($urandom_range(21));
            for (int i = 0; i < len; i++) begin
                logic [7:0] c;
                if ($urandom_range(39) == 0) begin
                    case ($urandom_range(3))
                        0: c = 8'h2F;
                        1: c = 8'h3A;
                        2: c = 8'h20;
                        default: c = 8'h61;
                    endcase
                end else begin
                    c = 8'h30 + 8'($urandom_range(9));
                end
                put(c, i == len - 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule